// File: doc/BRIEF.md
# Loop Compensation Filter With Dither

This block turns signed error samples from a fast loop converter into a duty-cycle code for a pulse-width generator in a voltage-mode power supply. Every sample that arrives with a valid strobe passes through a PID section (an integrator plus proportional and derivative paths). It then goes through one of two second stages. The first is a cascade of two one-pole low-pass sections, which gives the fastest response. The second is a boxcar (sinc) decimator, which averages a power-of-two number of PID results and gives quieter operation. The datapath is 22 bits wide with six fractional bits below the 9-bit duty code.

The six fractional bits can be converted into time-averaged resolution. When dither is enabled, a 16-bit maximal-length shift register supplies a uniform value of 0..63, which is added before truncation. The duty code then toggles between two adjacent codes in proportion to the fraction. Six tuning parameters (three PID gains, two low-pass shifts and the decimation exponent), the stage selection and the dither enable are captured together on a load strobe. Firmware can therefore retune the loop between samples, for example to widen the bandwidth during a load transient.

Top module: `loop_comp_filter`

## Requirements
- R1: After reset, duty is 0, duty_valid is 0, all gains and shifts are 0, the low-pass stage is selected and dither is off. A sample taken before any load therefore yields duty 0 with duty_valid high.
- R2: The cfg_* inputs are copied into the active set only in a cycle with cfg_load high, and they apply from the next err_valid onward. At any other time they have no effect on duty or duty_valid. A load produces no duty_valid and leaves duty unchanged.
- R3: Per sample e (with previous sample p, initially 0), the integrator becomes I' = sat(I + ki*e) and the PID result is sat(kp*e + I' + kd*(e - p)).
- R4: Every stage state (the integrator, both low-pass states and the decimator output) saturates to -2^21..2^21-1 and never wraps.
- R5: In low-pass mode, s1' = sat(s1 + ((pid - s1) >>> sh1)) and s2' = sat(s2 + ((s1' - s2) >>> sh2)), where >>> is an arithmetic (floor) shift. duty_valid pulses once, one cycle after each err_valid, and carries the value derived from s2'.
- R6: In sinc mode, the block sums 2^dec consecutive PID results and the stage value is sat(sum >>> dec). duty_valid pulses only for the last sample of each group. A load clears the partial sum and restarts the group count.
- R7: duty = clamp(floor((v + r) / 64), 0, 511), where v is the selected stage value and r is the dither value (0 when dither is off).
- R8: With dither on, r is bits [5:0] of a 16-bit shift register. The register is reset to 0xACE1 and steps once per err_valid (in every mode) as x <= {x[14:0], x[15]^x[13]^x[12]^x[10]}. r is taken before the step.
- R9: duty changes only in cycles where duty_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_valid | input | 1 | Error sample strobe |
| err | input | 8 | Signed error sample |
| cfg_load | input | 1 | Capture all cfg_* inputs into the active set |
| cfg_kp | input | 8 | Signed proportional gain |
| cfg_ki | input | 8 | Signed integral gain |
| cfg_kd | input | 8 | Signed derivative gain |
| cfg_sh1 | input | 3 | First low-pass section shift |
| cfg_sh2 | input | 3 | Second low-pass section shift |
| cfg_dec | input | 3 | Decimation exponent (group of 2^dec samples) |
| cfg_sinc | input | 1 | 1 selects the sinc decimator, 0 the low-pass stage |
| cfg_dither | input | 1 | 1 enables dither |
| duty | output | 9 | Duty-cycle code |
| duty_valid | output | 1 | Pulses when duty carries a new result |

## Verification
The bench drives the integrator far into saturation with maximum gain and error, and then reverses the error. A design that wraps would jump to the opposite rail partway through the run, and a design that saturates at the wrong bound would recover late. Decimation groups are checked across loads that arrive mid-group: a design that keeps its stale partial sum or count emits results at the wrong sample, or emits the wrong average. Gains are toggled on the inputs without a load, and dither is compared against the exact shift-register sequence. These checks expose designs that sample the configuration continuously, step the noise source only in dither mode, or round instead of floor.

// File: rtl/loop_comp_filter.sv
module loop_comp_filter #(
  parameter int IN_W  = 8,
  parameter int CW    = 8,
  parameter int W     = 22,
  parameter int OUT_W = 9,
  parameter int DW    = 6,
  parameter int SHW   = 3,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   err_valid,
  input  logic signed [IN_W-1:0] err,
  input  logic                   cfg_load,
  input  logic signed [CW-1:0]   cfg_kp,
  input  logic signed [CW-1:0]   cfg_ki,
  input  logic signed [CW-1:0]   cfg_kd,
  input  logic [SHW-1:0]         cfg_sh1,
  input  logic [SHW-1:0]         cfg_sh2,
  input  logic [SHW-1:0]         cfg_dec,
  input  logic                   cfg_sinc,
  input  logic                   cfg_dither,
  output logic [OUT_W-1:0]       duty,
  output logic                   duty_valid
);
  localparam int CNTW = 2**SHW - 1;
  localparam int SW   = W + CNTW;
  localparam int XW   = SW + 2;
  localparam logic signed [XW-1:0] HI   = XW'(2**(W-1) - 1);
  localparam logic signed [XW-1:0] LO   = -HI - 1;
  localparam logic signed [XW-1:0] QMAX = XW'(2**OUT_W - 1);

  function automatic logic signed [W-1:0] sat(input logic signed [XW-1:0] x);
    if (x > HI) return HI[W-1:0];
    if (x < LO) return LO[W-1:0];
    return x[W-1:0];
  endfunction

  logic signed [CW-1:0]   kp, ki, kd;
  logic [SHW-1:0]         sh1, sh2, dec;
  logic                   m_sinc, m_dith;
  logic signed [IN_W-1:0] prev_e;
  logic signed [W-1:0]    integ, lp1, lp2;
  logic signed [SW-1:0]   acc;
  logic [CNTW-1:0]        cnt;
  logic [15:0]            lfsr;

  logic signed [XW-1:0] ex, acc_n, rx, q;
  logic signed [W-1:0]  integ_n, pid, lp1_n, lp2_n, savg, v;
  logic                 last;
  logic [OUT_W-1:0]     duty_n;

  assign ex      = XW'(err);
  assign integ_n = sat(XW'(integ) + XW'(ki) * ex);
  assign pid     = sat(XW'(kp) * ex + XW'(integ_n) + XW'(kd) * (ex - XW'(prev_e)));
  assign lp1_n   = sat(XW'(lp1) + ((XW'(pid) - XW'(lp1)) >>> sh1));
  assign lp2_n   = sat(XW'(lp2) + ((XW'(lp1_n) - XW'(lp2)) >>> sh2));
  assign acc_n   = XW'(acc) + XW'(pid);
  assign last    = (cnt == CNTW'((32'd1 << dec) - 32'd1));
  assign savg    = sat(acc_n >>> dec);
  assign v       = m_sinc ? savg : lp2_n;
  assign rx      = m_dith ? XW'(lfsr[DW-1:0]) : '0;
  assign q       = (XW'(v) + rx) >>> DW;
  assign duty_n  = (q < 0) ? '0 : (q > QMAX) ? QMAX[OUT_W-1:0] : q[OUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kp <= '0; ki <= '0; kd <= '0;
      sh1 <= '0; sh2 <= '0; dec <= '0;
      m_sinc <= 1'b0; m_dith <= 1'b0;
      prev_e <= '0; integ <= '0; lp1 <= '0; lp2 <= '0;
      acc <= '0; cnt <= '0;
      lfsr <= SEED;
      duty <= '0; duty_valid <= 1'b0;
    end else begin
      duty_valid <= 1'b0;
      if (err_valid) begin
        prev_e <= err;
        integ  <= integ_n;
        lp1    <= lp1_n;
        lp2    <= lp2_n;
        lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (!m_sinc || last) begin
          duty <= duty_n;
          duty_valid <= 1'b1;
        end
        if (m_sinc && !last) begin
          acc <= acc_n[SW-1:0];
          cnt <= cnt + 1'b1;
        end else begin
          acc <= '0;
          cnt <= '0;
        end
      end
      if (cfg_load) begin
        kp <= cfg_kp; ki <= cfg_ki; kd <= cfg_kd;
        sh1 <= cfg_sh1; sh2 <= cfg_sh2; dec <= cfg_dec;
        m_sinc <= cfg_sinc; m_dith <= cfg_dither;
        acc <= '0; cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/loop_comp_filter_chk.sv
module loop_comp_filter_chk #(
  parameter int OUT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             err_valid,
  input logic [OUT_W-1:0] duty,
  input logic             duty_valid,
  input logic             m_sinc,
  input logic [15:0]      lfsr
);
  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) lfsr != 16'd0); // R8
  AST_LFSR_STEP: assert property (@(posedge clk) disable iff (!rst_n) err_valid |=> lfsr != $past(lfsr)); // R8
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !err_valid |=> $stable(lfsr)); // R8
  AST_VALID_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) duty_valid |-> $past(err_valid)); // R5
  AST_LPF_EVERY_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) (err_valid && !m_sinc) |=> duty_valid); // R5
  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !duty_valid |-> $stable(duty)); // R9
endmodule

bind loop_comp_filter loop_comp_filter_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .duty(duty),
  .duty_valid(duty_valid), .m_sinc(m_sinc), .lfsr(lfsr)
);

// File: tb/test_loop_comp_filter.sv
`timescale 1ns/1ps
module test_loop_comp_filter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic err_valid = 1'b0, cfg_load = 1'b0;
  logic signed [7:0] err = '0, cfg_kp = '0, cfg_ki = '0, cfg_kd = '0;
  logic [2:0] cfg_sh1 = '0, cfg_sh2 = '0, cfg_dec = '0;
  logic cfg_sinc = 1'b0, cfg_dither = 1'b0;
  logic [8:0] duty;
  logic duty_valid;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  loop_comp_filter i_loop_comp_filter (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err(err),
    .cfg_load(cfg_load), .cfg_kp(cfg_kp), .cfg_ki(cfg_ki), .cfg_kd(cfg_kd),
    .cfg_sh1(cfg_sh1), .cfg_sh2(cfg_sh2), .cfg_dec(cfg_dec),
    .cfg_sinc(cfg_sinc), .cfg_dither(cfg_dither),
    .duty(duty), .duty_valid(duty_valid)
  );

  // reference state
  longint kp = 0, ki = 0, kd = 0, sh1 = 0, sh2 = 0, dec = 0;
  bit msinc = 0, mdith = 0;
  longint m_prev = 0, m_integ = 0, m_lp1 = 0, m_lp2 = 0, m_acc = 0, m_cnt = 0;
  logic [15:0] m_lfsr = 16'hACE1;
  longint m_duty = 0;
  bit m_valid = 0;

  function automatic longint sat(longint x);
    if (x > 2097151) return 2097151;
    if (x < -2097152) return -2097152;
    return x;
  endfunction

  task automatic model(longint e);
    longint in_, pid, l1, l2, accn, sav, v, r, q;
    bit last;
    in_  = sat(m_integ + ki * e);
    pid  = sat(kp * e + in_ + kd * (e - m_prev));
    l1   = sat(m_lp1 + ((pid - m_lp1) >>> sh1));
    l2   = sat(m_lp2 + ((l1 - m_lp2) >>> sh2));
    accn = m_acc + pid;
    last = (m_cnt == (64'sd1 <<< dec) - 1);
    sav  = sat(accn >>> dec);
    v    = msinc ? sav : l2;
    r    = mdith ? longint'(m_lfsr[5:0]) : 0;
    q    = (v + r) >>> 6;
    if (q < 0) q = 0;
    if (q > 511) q = 511;
    m_prev = e; m_integ = in_; m_lp1 = l1; m_lp2 = l2;
    m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    m_valid = !msinc || last;
    if (m_valid) m_duty = q;
    if (msinc && !last) begin m_acc = accn; m_cnt++; end
    else begin m_acc = 0; m_cnt = 0; end
  endtask

  task automatic check(string tag);
    n_chk++;
    if (duty_valid !== m_valid || duty !== m_duty[8:0]) begin
      n_fail++;
      $display("FAIL %s: duty=%0d valid=%0b expected duty=%0d valid=%0b",
               tag, duty, duty_valid, m_duty, m_valid);
    end
  endtask

  task automatic send(longint e, string tag);
    err = 8'(e); err_valid = 1'b1;
    @(negedge clk);
    err_valid = 1'b0;
    model(e);
    check(tag);
  endtask

  task automatic load(int p, int i, int d, int s1, int s2, int dc, bit sn, bit di);
    cfg_kp = 8'(p); cfg_ki = 8'(i); cfg_kd = 8'(d);
    cfg_sh1 = 3'(s1); cfg_sh2 = 3'(s2); cfg_dec = 3'(dc);
    cfg_sinc = sn; cfg_dither = di; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    kp = p; ki = i; kd = d; sh1 = s1; sh2 = s2; dec = dc;
    msinc = sn; mdith = di; m_acc = 0; m_cnt = 0;
    m_valid = 0;
    check("R2 load");
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
    m_valid = 0;
    check("R9 idle");
  endtask

  initial begin
    int s;
    s = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_valid = 0;
    check("R1 reset");
    send(100, "R1 zero gains");

    // proportional only, low-pass bypass (shift 0)
    load(16, 0, 0, 0, 0, 0, 0, 0);
    send(10, "R3 prop");
    send(-5, "R7 clamp low");
    send(127, "R3 prop");
    // derivative and integral
    load(0, 20, 40, 0, 0, 0, 0, 0);
    for (int k = 0; k < 6; k++) send(k * 9 - 20, "R3 pid");

    // inputs move without load: ignored
    cfg_kp = 8'sd127; cfg_ki = -8'sd100; cfg_sinc = 1'b1; cfg_dither = 1'b1;
    idle(3);
    for (int k = 0; k < 4; k++) send(50, "R2 ignored");

    // integrator saturation and recovery
    load(0, 127, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 200; k++) send(127, "R4 sat high");
    for (int k = 0; k < 300; k++) send(-128, "R4 sat low");
    for (int k = 0; k < 150; k++) send(127, "R4 recover");

    // two-pole smoothing
    load(64, 0, 0, 2, 3, 0, 0, 0);
    for (int k = 0; k < 20; k++) send(100, "R5 lpf step");

    // sinc decimation, load mid-group restarts the group
    load(64, 1, 0, 0, 0, 2, 1, 0);
    for (int k = 0; k < 10; k++) send(k * 5, "R6 sinc");
    load(64, 1, 0, 0, 0, 3, 1, 0);
    for (int k = 0; k < 17; k++) send(30 - k, "R6 regroup");
    load(32, 0, 0, 0, 0, 0, 1, 0);
    for (int k = 0; k < 4; k++) send(k, "R6 dec0");

    // dither with fractional values
    load(3, 0, 0, 0, 0, 0, 0, 1);
    for (int k = 0; k < 64; k++) send(37, "R8 dither");
    load(3, 0, 0, 0, 0, 1, 1, 1);
    for (int k = 0; k < 32; k++) send(-3 + (k % 7), "R8 dither sinc");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int c;
      c = $urandom_range(0, 99);
      if (c < 3)
        load($urandom_range(0, 80) - 40, $urandom_range(0, 10) - 5, $urandom_range(0, 60) - 30,
             $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 5),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      else if (c < 8) begin
        cfg_kp = 8'($urandom); cfg_sinc = 1'($urandom);
        idle($urandom_range(1, 3));
      end else
        send(longint'($urandom_range(0, 255)) - 128, "R7 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule